// File: doc/BRIEF.md
# Asynchronous Serial Byte Transmitter

This block sends one byte at a time over a single serial line using the common asynchronous framing: one low start bit, eight data bits with the least significant bit first, and one high stop bit, with no parity. The line sits high while nothing is being sent. A user offers a byte by raising `go` while `ready` is high. The byte is taken on that clock edge, and `ready` stays low until the stop bit has ended.

The bit time comes from two parameters, the clock frequency and the baud rate. Their integer quotient is the reload value of a down-counter, and each bit lasts that value plus one clock cycle. A ten-bit one-hot phase word tracks where the frame is: all zeros means idle, the lowest bit means the start bit, and the highest bit means the stop bit. The phase word moves up one place at the end of each bit. The line is driven from the bottom of a nine-bit shift buffer. The buffer shifts right once per bit and fills with ones from the top, so it ends every frame, and powers up, in the all-ones idle state.

Top module: `onehot_uart_tx`

## Requirements
- R1: After reset `tx` is 1 and `ready` is 1.
- R2: On a clock edge where `ready` and `go` are both 1, the byte on `data` is accepted. From the next cycle `ready` is 0 and `tx` is 0 (start bit).
- R3: Every bit of the frame, including start and stop, holds `tx` constant for exactly CLK_HZ/BAUD + 1 cycles (integer division).
- R4: After the start bit, the eight data bits appear on `tx` with `data[0]` first and `data[7]` last.
- R5: The tenth bit is a stop bit with `tx` = 1. `ready` returns to 1 exactly 10 bit times after the accepting edge.
- R6: `ready` is 1 exactly when no frame is in progress. A `go` in the first cycle that `ready` is 1 again starts the next frame with no idle gap.
- R7: While `ready` is 0, `go` and `data` have no effect: the frame in progress completes unchanged and no new frame is queued.
- R8: While `ready` is 1 and `go` is 0, `tx` stays 1 and `ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| go | input | 1 | Request to send `data`; taken only while `ready` is 1 |
| data | input | DATA_W (8) | Byte to send, sampled on the accepting edge |
| tx | output | 1 | Serial line, idles high |
| ready | output | 1 | High when a new byte can be accepted |

## Verification
The assertions assume that `go` and `data` change only away from the rising edge, and that reset is held for at least one edge before any property is checked. They also assume CLK_HZ is at least BAUD, so the reload value is not zero. The stimulus drives every input on the falling edge. It raises `go` only from tasks that either wait for `ready` or deliberately toggle `go` and `data` in the middle of a frame to show that both are ignored. It sends bytes back to back by raising `go` in the first cycle that `ready` returns.

// File: rtl/utx_pkg.sv
package utx_pkg;

  // Cycles loaded into the bit timer: one bit lasts this value plus one.
  function automatic int unsigned bit_reload(input int unsigned clk_hz,
                                             input int unsigned baud);
    return clk_hz / baud;
  endfunction

  // Width needed to hold the reload value (at least one bit).
  function automatic int unsigned timer_width(input int unsigned reload);
    return (reload < 2) ? 1 : $clog2(reload + 1);
  endfunction

endpackage

// File: rtl/utx_bit_timer.sv
module utx_bit_timer #(
  parameter int unsigned RELOAD = 4,
  parameter int unsigned CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  output logic             tick,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(RELOAD);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = LOAD_V;
    else if (run)
      cnt_d = at_zero ? LOAD_V : cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run & at_zero;
  assign cnt  = cnt_q;
endmodule

// File: rtl/utx_phase_ring.sv
module utx_phase_ring #(
  parameter int unsigned PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tick,
  output logic [PW-1:0] phase,
  output logic          idle
);
  localparam logic [PW-1:0] START_P = PW'(1);

  logic [PW-1:0] ph_q, ph_d;

  // Shifting left moves the one-hot bit onward; the stop bit falls off
  // the top, leaving zero, which is the idle encoding.
  always_comb begin
    ph_d = ph_q;
    if (start)
      ph_d = START_P;
    else if (tick)
      ph_d = {ph_q[PW-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;
  assign idle  = ~|ph_q;
endmodule

// File: rtl/utx_shift_buf.sv
module utx_shift_buf #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic [DW-1:0] din,
  output logic          line
);
  localparam int unsigned BW = DW + 1;

  logic [BW-1:0] sb_q, sb_d;

  always_comb begin
    sb_d = sb_q;
    if (load)
      sb_d = {din, 1'b0};
    else if (shift)
      sb_d = {1'b1, sb_q[BW-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sb_q <= '1;
    else        sb_q <= sb_d;
  end

  assign line = sb_q[0];
endmodule

// File: rtl/onehot_uart_tx.sv
module onehot_uart_tx #(
  parameter int unsigned CLK_HZ = 1_000_000,
  parameter int unsigned BAUD   = 250_000,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DATA_W-1:0] data,
  output logic              tx,
  output logic              ready
);
  localparam int unsigned RELOAD_V = utx_pkg::bit_reload(CLK_HZ, BAUD);
  localparam int unsigned CNT_W    = utx_pkg::timer_width(RELOAD_V);
  localparam int unsigned PW       = DATA_W + 2;

  // Named internal events, also observed by the bound checker.
  logic             accept_go;
  logic             busy;
  logic             bit_tick;
  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    phase_q;
  logic             idle;

  assign accept_go = idle & go;
  assign busy      = ~idle;

  utx_bit_timer #(.RELOAD(RELOAD_V), .CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept_go),
    .run   (busy),
    .tick  (bit_tick),
    .cnt   (cnt_q)
  );

  utx_phase_ring #(.PW(PW)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept_go),
    .tick  (bit_tick),
    .phase (phase_q),
    .idle  (idle)
  );

  utx_shift_buf #(.DW(DATA_W)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept_go),
    .shift (bit_tick),
    .din   (data),
    .line  (tx)
  );

  assign ready = idle;
endmodule

// File: rtl/onehot_uart_tx_chk.sv
module onehot_uart_tx_chk #(
  parameter int unsigned PW     = 10,
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned RELOAD = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             tx,
  input logic             ready,
  input logic [PW-1:0]    phase,
  input logic             bit_tick,
  input logic [CNT_W-1:0] cnt
);
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> tx);

  a_r2_start_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ready && go |=> !ready && !tx);

  a_r3_tx_steady_in_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !ready && !bit_tick |=> $stable(tx));

  a_r3_timer_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(RELOAD));

  a_r5_stop_is_high: assert property (@(posedge clk) disable iff (!rst_n)
    phase[PW-1] |-> tx);

  a_r5_ready_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    phase[PW-1] && bit_tick |=> ready);

  a_r6_phase_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase));

  a_r7_go_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !ready && go && !phase[0] |=> !phase[0]);
endmodule

bind onehot_uart_tx onehot_uart_tx_chk #(
  .PW(PW), .CNT_W(CNT_W), .RELOAD(RELOAD_V)
) i_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .tx(tx), .ready(ready),
  .phase(phase_q), .bit_tick(bit_tick), .cnt(cnt_q)
);

// File: tb/test_onehot_uart_tx.sv
module test_onehot_uart_tx;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned CLK_HZ = 1_000_000;
  localparam int unsigned BAUD   = 250_000;
  localparam int BITCYC = CLK_HZ / BAUD + 1;   // R3: cycles per bit

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go = 1'b0;
  logic [7:0] data = 8'h00;
  logic       tx, ready;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit cmp_on = 0;

  onehot_uart_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(8)) i_onehot_uart_tx (
    .clk(clk), .rst_n(rst_n), .go(go), .data(data), .tx(tx), .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: bit index (-1 idle), cycle within bit, held byte.
  int         m_bit = -1;
  int         m_cyc = 0;
  logic [7:0] m_byte = 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bit = -1;
    end else if (m_bit < 0) begin
      if (go) begin
        m_bit = 0; m_cyc = 0; m_byte = data;
      end
    end else begin
      m_cyc = m_cyc + 1;
      if (m_cyc == BITCYC) begin
        m_cyc = 0;
        m_bit = m_bit + 1;
        if (m_bit == 10) m_bit = -1;
      end
    end
  end

  function automatic logic exp_tx();
    if (m_bit < 0 || m_bit == 9) return 1'b1;
    if (m_bit == 0) return 1'b0;
    return m_byte[m_bit-1];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the reference.
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      string t;
      t = (m_bit < 0) ? "R8 line" : (m_bit == 0) ? "R2 start" :
          (m_bit == 9) ? "R5 stop" : "R4 data";
      chk(t, {31'd0, tx}, {31'd0, exp_tx()});
      chk("R6 ready", {31'd0, ready}, {31'd0, (m_bit < 0)});
    end
  end

  // Offer a byte (waiting for ready), then watch the frame until ready returns.
  // noisy=1 toggles go and data during the frame (R7).
  task automatic send_frame(input logic [7:0] b, input bit noisy, input string tag);
    logic [9:0] smp;
    int cyc;
    int low_run;
    while (ready !== 1'b1) @(negedge clk);
    go = 1'b1; data = b;
    @(negedge clk);
    go = 1'b0;
    chk({tag, " R2 ready low after accept"}, {31'd0, ready}, 32'd0);
    cyc = 0; low_run = 0; smp = '0;
    while (ready !== 1'b1 && cyc < 20*BITCYC) begin
      if (cyc % BITCYC == BITCYC/2) smp[cyc / BITCYC] = tx;
      if (cyc < BITCYC && tx === 1'b0) low_run++;
      if (noisy) begin go = ~go; data = ~data; end
      cyc++;
      @(negedge clk);
    end
    go = 1'b0;
    chk({tag, " R5 frame length"}, cyc, 10*BITCYC);
    chk({tag, " R2 start bit"}, {31'd0, smp[0]}, 32'd0);
    chk({tag, " R4 data bits"}, {24'd0, smp[8:1]}, {24'd0, b});
    chk({tag, " R5 stop bit"}, {31'd0, smp[9]}, 32'd1);
    chk({tag, " R3 start width"}, low_run, BITCYC);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    go = 1'b1;                     // go during reset must do nothing
    repeat (3) @(negedge clk);
    go = 1'b0;
    chk("R1 tx after reset", {31'd0, tx}, 32'd1);
    chk("R1 ready after reset", {31'd0, ready}, 32'd1);
    rst_n = 1'b1;
    cmp_on = 1;
    repeat (8) @(negedge clk);
    chk("R8 idle tx", {31'd0, tx}, 32'd1);
    chk("R8 idle ready", {31'd0, ready}, 32'd1);

    send_frame(8'hA5, 0, "A5");
    send_frame(8'hFF, 0, "FF");    // R3: only the start bit is low
    send_frame(8'h00, 0, "00");
    send_frame(8'h80, 1, "80 R7 noisy");
    // R6: back to back, go in the first ready cycle
    send_frame(8'h01, 0, "01 R6 back-to-back");
    send_frame(8'h3C, 1, "3C R7 noisy");
    repeat (6) @(negedge clk);
    chk("R8 final idle", {31'd0, tx}, 32'd1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule